// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block decides which frames (area-scan) or lines (line-scan) coming from a camera are accepted for capture. It watches the frame-valid and line-valid strobes and one external trigger line, which is picked from a small bank of inputs by a selector. Its output is a registered capture-enable. The enable opens only on a frame-valid rising edge, or on a line-valid rising edge in envelope mode, and it closes when that strobe drops. Capture therefore never starts partway through a frame.

Configuration arrives as static inputs. These set the capture policy, the trigger polarity, edge or level detection, and a trigger delay. The delay is counted either in ticks of an external 1 µs timebase or in line-valid rising edges. The delay timer cannot be retriggered. A trigger that arrives while a delay is still running is discarded, and the block reports this with a one-cycle status pulse.

Top module: `acq_trig_ctrl`

## Requirements
- R1: With `mode_i`=0 (free-run), `acq_en_o` goes to 1 in the cycle after every frame-valid rising edge, whatever the trigger state. It returns to 0 in the cycle after frame-valid is sampled low, in every frame mode (`mode_i` 0, 1 or 2).
- R2: With `mode_i`=1 (start-once), no frame is captured before the first trigger fires. After it fires, every later frame is captured until the mode changes.
- R3: With `mode_i`=2 (one-shot), each firing enables exactly one frame. Firings that occur while a frame grant is still waiting merge into that single grant.
- R4: A firing inside a frame leaves that frame uncaptured and takes effect at the next frame-valid rising edge. A firing in the same cycle as the rising edge does capture that frame.
- R5: The trigger is bit `trig_sel_i` of `trig_src_i`, and it is active when it equals `trig_pol_i`. When `trig_edge_i`=1, an event is an inactive-to-active transition. When `trig_edge_i`=0, every active cycle is an event. Unselected inputs have no effect.
- R6: With `mode_i`=3 (envelope), at each line-valid rising edge `acq_en_o` takes the trigger's active state. It holds that value for the rest of the line and drops in the cycle after line-valid is low. Frame-valid is ignored in this mode.
- R7: With `dly_lines_i`=0 and `dly_val_i`=N>0, an accepted event fires on the N-th `tick_us_i` pulse that comes after the event cycle.
- R8: With `dly_lines_i`=1, the delay counts line-valid rising edges instead of ticks.
- R9: With `dly_val_i`=0, an accepted event fires in the same cycle it is detected.
- R10: An event that arrives while a delay is pending neither restarts the delay nor adds a firing.
- R11: `drop_o` is high for one cycle, in the cycle after each event that is discarded because a delay is pending.
- R12: During reset and directly after it, `acq_en_o` and `drop_o` are 0 and no delay is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fval_i | input | 1 | Frame-valid strobe |
| lval_i | input | 1 | Line-valid strobe |
| trig_src_i | input | NUM_SRC | Candidate trigger inputs |
| trig_sel_i | input | SEL_W | Index of the trigger input in use |
| trig_pol_i | input | 1 | Active level of the trigger |
| trig_edge_i | input | 1 | 1 selects edge detection, 0 selects level detection |
| mode_i | input | 2 | 0 free-run, 1 start-once, 2 one-shot, 3 envelope |
| tick_us_i | input | 1 | 1 µs timebase pulse |
| dly_lines_i | input | 1 | 1 counts the delay in lines, 0 in microseconds |
| dly_val_i | input | DLY_W | Delay length; 0 means no delay |
| acq_en_o | output | 1 | Capture enable |
| drop_o | output | 1 | Pulse when a trigger is discarded |

## Verification
A corrupted delay count shows up as a grant that lands one tick early or late. A frame run straight after the final tick exposes it: that frame is captured when it should not be, or missed when it should be. A stuck grant flag in start-once or one-shot mode shows as a wrong capture-enable on the very next frame-valid rising edge. A wrong busy state shows at `drop_o` in the cycle after the second trigger, and at the frame after the delay ends, where a firing appears extra or is missing.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_START    = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_ENVELOPE = 2'd3
  } acq_mode_e;
endpackage

// File: rtl/acq_trig_detect.sv
module acq_trig_detect #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               pol_i,
  input  logic               edge_i,
  output logic               act_o,
  output logic               evt_o
);
  logic raw, act_q;

  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_i == SEL_W'(i)) raw = src_i[i];
  end

  assign act_o = (raw == pol_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_o;

  assign evt_o = edge_i ? (act_o & ~act_q) : act_o;
endmodule

// File: rtl/acq_trig_delay.sv
module acq_trig_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             tick_us_i,
  input  logic             lval_i,
  input  logic             in_lines_i,
  input  logic [DLY_W-1:0] dly_val_i,
  output logic             fire_o,
  output logic             busy_o,
  output logic             drop_o
);
  logic [DLY_W-1:0] cnt_q;
  logic lval_q, step, accept;

  assign busy_o = (cnt_q != '0);
  assign step   = in_lines_i ? (lval_i & ~lval_q) : tick_us_i;
  assign accept = evt_i & ~busy_o;
  assign fire_o = (accept & (dly_val_i == '0)) |
                  (busy_o & step & (cnt_q == DLY_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      lval_q <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      lval_q <= lval_i;
      drop_o <= evt_i & busy_o;
      if (accept && dly_val_i != '0) cnt_q <= dly_val_i;
      else if (busy_o && step)       cnt_q <= cnt_q - DLY_W'(1);
    end
endmodule

// File: rtl/acq_trig_gate.sv
module acq_trig_gate
  import acq_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       fval_i,
  input  logic       lval_i,
  input  logic       trig_act_i,
  input  logic       fire_i,
  output logic       acq_en_o
);
  acq_mode_e mode;
  logic fval_q, lval_q, started_q, pend_q, grant;
  logic fval_rise, lval_rise;

  assign mode      = acq_mode_e'(mode_i);
  assign fval_rise = fval_i & ~fval_q;
  assign lval_rise = lval_i & ~lval_q;

  always_comb
    case (mode)
      MODE_FREE:    grant = 1'b1;
      MODE_START:   grant = started_q | fire_i;
      MODE_ONESHOT: grant = pend_q | fire_i;
      default:      grant = 1'b0;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      fval_q    <= 1'b0;
      lval_q    <= 1'b0;
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      acq_en_o  <= 1'b0;
    end else begin
      fval_q    <= fval_i;
      lval_q    <= lval_i;
      started_q <= (mode == MODE_START) & (started_q | fire_i);
      pend_q    <= (mode == MODE_ONESHOT) & ~fval_rise & (pend_q | fire_i);
      if (mode == MODE_ENVELOPE) begin
        if (!lval_i)        acq_en_o <= 1'b0;
        else if (lval_rise) acq_en_o <= trig_act_i;
      end else begin
        if (!fval_i)        acq_en_o <= 1'b0;
        else if (fval_rise) acq_en_o <= grant;
      end
    end
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int DLY_W   = 8,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fval_i,
  input  logic               lval_i,
  input  logic [NUM_SRC-1:0] trig_src_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic               trig_pol_i,
  input  logic               trig_edge_i,
  input  logic [1:0]         mode_i,
  input  logic               tick_us_i,
  input  logic               dly_lines_i,
  input  logic [DLY_W-1:0]   dly_val_i,
  output logic               acq_en_o,
  output logic               drop_o
);
  logic trig_act, trig_evt, trig_fire, dly_busy;

  acq_trig_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (trig_src_i),
    .sel_i  (trig_sel_i),
    .pol_i  (trig_pol_i),
    .edge_i (trig_edge_i),
    .act_o  (trig_act),
    .evt_o  (trig_evt)
  );

  acq_trig_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (trig_evt),
    .tick_us_i  (tick_us_i),
    .lval_i     (lval_i),
    .in_lines_i (dly_lines_i),
    .dly_val_i  (dly_val_i),
    .fire_o     (trig_fire),
    .busy_o     (dly_busy),
    .drop_o     (drop_o)
  );

  acq_trig_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .fval_i     (fval_i),
    .lval_i     (lval_i),
    .trig_act_i (trig_act),
    .fire_i     (trig_fire),
    .acq_en_o   (acq_en_o)
  );
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fval_i,
  input logic             lval_i,
  input logic [1:0]       mode_i,
  input logic [DLY_W-1:0] dly_val_i,
  input logic             acq_en_o,
  input logic             drop_o,
  input logic             trig_evt,
  input logic             trig_fire,
  input logic             dly_busy
);
  logic fval_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fval_seen_q <= 1'b0;
    else         fval_seen_q <= fval_i;

  p_frame_close_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fval_i && mode_i != 2'd3) |=> !acq_en_o);

  p_free_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && fval_i && !fval_seen_q) |=> acq_en_o);

  p_no_partial_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd3 && fval_i && fval_seen_q && !acq_en_o) |=> !acq_en_o);

  p_env_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !lval_i) |=> !acq_en_o);

  p_zero_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_evt && !dly_busy && dly_val_i == '0) |-> trig_fire);

  p_drop_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_evt && dly_busy) |=> drop_o);

  p_no_drop_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dly_busy |=> !drop_o);
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fval_i    (fval_i),
  .lval_i    (lval_i),
  .mode_i    (mode_i),
  .dly_val_i (dly_val_i),
  .acq_en_o  (acq_en_o),
  .drop_o    (drop_o),
  .trig_evt  (trig_evt),
  .trig_fire (trig_fire),
  .dly_busy  (dly_busy)
);

// File: tb/acq_trig_ctrl_tb.sv
module acq_trig_ctrl_tb;
  localparam int NUM_SRC = 4;
  localparam int DLY_W   = 8;
  localparam int SEL_W   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fval = 0, lval = 0, pol = 1, edge_m = 1, tick = 0, in_lines = 0;
  logic [NUM_SRC-1:0] src = '0;
  logic [SEL_W-1:0] sel = 2'd2;
  logic [1:0] mode = 2'd0;
  logic [DLY_W-1:0] dly = '0;
  logic acq_en, drop;
  int checks = 0, errors = 0;
  bit got;

  always #10 clk = ~clk;

  acq_trig_ctrl #(.NUM_SRC(NUM_SRC), .DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fval_i(fval), .lval_i(lval),
    .trig_src_i(src), .trig_sel_i(sel), .trig_pol_i(pol), .trig_edge_i(edge_m),
    .mode_i(mode), .tick_us_i(tick), .dly_lines_i(in_lines), .dly_val_i(dly),
    .acq_en_o(acq_en), .drop_o(drop)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(output bit g);
    fval = 1; step();
    g = acq_en;
    repeat (3) step();
    fval = 0; step();
    chk("R1 frame close", acq_en, 1'b0);
    step();
  endtask

  task automatic pulse_src(int s);
    src[s] = pol; step();
    src[s] = ~pol; step();
  endtask

  task automatic pulse_tick();
    tick = 1; step();
    tick = 0; step();
  endtask

  task automatic pulse_line();
    lval = 1; step();
    lval = 0; step();
  endtask

  task automatic set_mode(logic [1:0] m);
    mode = 2'd0; step();
    mode = m; step();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12 reset
    step();
    chk("R12 reset acq_en", acq_en, 1'b0);
    chk("R12 reset drop", drop, 1'b0);
    rst_ni = 1; step();
    chk("R12 post reset acq_en", acq_en, 1'b0);
    chk("R12 post reset drop", drop, 1'b0);

    // R1 free-run, trigger idle
    set_mode(2'd0);
    for (int f = 0; f < 3; f++) begin
      run_frame(got); chk("R1 free-run frame", got, 1'b1);
    end

    // R2 start-once
    set_mode(2'd1);
    run_frame(got); chk("R2 before trigger", got, 1'b0);
    pulse_src(2);
    for (int f = 0; f < 3; f++) begin
      run_frame(got); chk("R2 after trigger", got, 1'b1);
    end

    // R5 source selection sweep, one-shot mode
    for (int s = 0; s < NUM_SRC; s++) begin
      sel = SEL_W'(s);
      set_mode(2'd2);
      for (int o = 0; o < NUM_SRC; o++) if (o != s) pulse_src(o);
      run_frame(got); chk("R5 unselected ignored", got, 1'b0);
      pulse_src(s);
      run_frame(got); chk("R5 selected fires", got, 1'b1);
    end
    sel = 2'd2;

    // R3 coalescing of two firings into one frame
    set_mode(2'd2);
    pulse_src(2); pulse_src(2);
    run_frame(got); chk("R3 one frame granted", got, 1'b1);
    run_frame(got); chk("R3 no second frame", got, 1'b0);

    // R5 low polarity
    pol = 0; src = '1; step();
    pulse_src(2);
    run_frame(got); chk("R5 low polarity fires", got, 1'b1);
    pol = 1; src = '0; set_mode(2'd2);

    // R4 mid-frame firing
    fval = 1; step(); step();
    src[2] = 1; step(); src[2] = 0; step();
    chk("R4 mid-frame no capture", acq_en, 1'b0);
    fval = 0; step(); step();
    run_frame(got); chk("R4 next frame captured", got, 1'b1);
    // R4/R9 firing at the rising edge, zero delay
    fval = 1; src[2] = 1; step();
    chk("R9 same-cycle fire captures", acq_en, 1'b1);
    src[2] = 0; step(); fval = 0; step(); step();

    // R5 level mode
    edge_m = 0; src[2] = 1;
    run_frame(got); chk("R5 level frame 1", got, 1'b1);
    run_frame(got); chk("R5 level frame 2", got, 1'b1);
    src[2] = 0; run_frame(got);
    run_frame(got); chk("R5 level released", got, 1'b0);
    edge_m = 1;

    // R6 envelope
    set_mode(2'd3);
    fval = 1;
    src[2] = 1; lval = 1; step();
    chk("R6 line while active", acq_en, 1'b1);
    src[2] = 0; step();
    chk("R6 held within line", acq_en, 1'b1);
    lval = 0; step();
    chk("R6 line end", acq_en, 1'b0);
    lval = 1; step();
    chk("R6 inactive line", acq_en, 1'b0);
    lval = 0; fval = 0; step();
    src[2] = 1; lval = 1; step();
    chk("R6 fval ignored", acq_en, 1'b1);
    lval = 0; src[2] = 0; step();

    // R7 microsecond delay sweep
    set_mode(2'd2);
    in_lines = 0;
    for (int n = 1; n <= 4; n++) begin
      dly = DLY_W'(n);
      pulse_src(2);
      for (int k = 0; k < n - 1; k++) pulse_tick();
      run_frame(got); chk("R7 not yet fired", got, 1'b0);
      pulse_tick();
      run_frame(got); chk("R7 fired on last tick", got, 1'b1);
    end

    // R8 line delay
    in_lines = 1; dly = 2;
    pulse_src(2);
    pulse_line();
    run_frame(got); chk("R8 one line early", got, 1'b0);
    pulse_line();
    run_frame(got); chk("R8 fired after lines", got, 1'b1);

    // R10/R11 non-retriggerable
    in_lines = 0; dly = 3;
    pulse_src(2);
    pulse_tick();
    src[2] = 1; step();
    chk("R11 drop pulse", drop, 1'b1);
    src[2] = 0; step();
    chk("R11 drop single cycle", drop, 1'b0);
    pulse_tick(); pulse_tick();
    run_frame(got); chk("R10 original timing kept", got, 1'b1);
    pulse_tick(); pulse_tick(); pulse_tick();
    run_frame(got); chk("R10 no extra firing", got, 1'b0);
    chk("R11 idle no drop", drop, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule